// File: doc/BRIEF.md
# Shift-Register Byte Handshake Controller

This block is the device side of a three-wire byte handshake between a host and a microcontroller. The host drives two active-low lines, one marking that a transfer is in progress and one that acknowledges each byte. The block drives a third active-low line that requests a transfer. Bytes pass through an 8-bit shift register that the local processor reads and writes over a small register bus. A bit in an auxiliary control register picks the direction of travel.

Bytes are not moved by a serial clock. A byte moves whenever the pair (transfer line, acknowledge line) differs from its level on the previous clock. Host-to-device bytes are stored in a 16-entry receive store. Device-to-host bytes come from a 128-entry reply store, which the processor fills and then commits with a length. When the host releases the transfer line, a packet ends: the block raises its shift interrupt flag and, if any bytes arrived, gives a one-cycle packet-complete strobe carrying the byte count. While the host is idle, a change on the acknowledge line is mirrored onto the request line (sync mode).

A two-state machine tracks the transfer line. It has the states IDLE (line released) and ACTIVE (line held low). START moves IDLE to ACTIVE when the line falls, and FINISH moves ACTIVE to IDLE when it rises. Together with a registered copy of the acknowledge level, the state gives the previous-cycle view of both lines that all change detection uses.

Top module: `shift_handshake`

## Requirements
- R1: After reset, `req_n` is 1, `sr_irq` is 0 and `pkt_done` is 0, and a read of offset 10 returns 0.
- R2: Bit 4 of the auxiliary register (offset 11) set to 1 selects host-to-device. In that direction, while `xfer_n` is 0, every cycle in which {`xfer_n`,`ack_n`} differs from the previous cycle stores the shift register into the next receive slot, starting at slot 0, and sets `sr_irq` one clock later. Slot k is read combinationally at `rx_rd_data` with `rx_rd_idx` = k.
- R3: Once 16 bytes are held in one packet, further byte events store nothing, leave the stored slots unchanged and do not set `sr_irq`.
- R4: Bit 4 set to 0 selects device-to-host. In that direction, while `xfer_n` is 0, each change of the pair with reply bytes pending loads the next reply byte into the shift register and sets `sr_irq`. A change with nothing pending leaves the shift register and `sr_irq` unchanged.
- R5: The clock edge that loads the last pending reply byte also drives `req_n` to 1.
- R6: When `xfer_n` is 1 in this cycle and in the previous one, a change of `ack_n` sets `req_n` to the new `ack_n` level and sets `sr_irq` (sync mode).
- R7: A rise of `xfer_n` always sets `sr_irq`. If the packet received at least one byte, `pkt_done` pulses for exactly one cycle with `pkt_len` equal to the count, and the count returns to 0.
- R8: While `xfer_n` is 1 and the sync case of R6 does not apply, pending reply bytes drive `req_n` to 0.
- R9: Reading offset 10 returns the shift register and clears `sr_irq`. Writing offset 10 loads it. A flag set in the same cycle as a read takes priority, so the flag stays 1.
- R10: `tx_commit` sets the reply index to 0 and the pending length to `tx_commit_len`, so a later transfer starts again from reply slot 0.
- R11: Offset 11 reads back the auxiliary register. Every other offset except 10 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_n | input | 1 | Host transfer-in-progress line, active low |
| ack_n | input | 1 | Host acknowledge line, active low |
| req_n | output | 1 | Transfer request line to host, active low |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| sr_irq | output | 1 | Shift interrupt flag |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_len | output | 5 | Byte count that goes with `pkt_done` |
| rx_rd_idx | input | 4 | Receive slot to view |
| rx_rd_data | output | 8 | Content of the selected receive slot |
| tx_wr_en | input | 1 | Reply store write enable |
| tx_wr_idx | input | 7 | Reply store write slot |
| tx_wr_data | input | 8 | Reply store write data |
| tx_commit | input | 1 | Commit reply: reset index, set length |
| tx_commit_len | input | 8 | Reply length, up to 128 |

## Verification
Every handshake result (`req_n`, `sr_irq`, `pkt_done`/`pkt_len` and the shift register) is registered, so it appears on the first rising edge after the line levels change. The bench drives inputs just after a falling edge and samples at the next falling edge. Register reads and receive-slot views are combinational, so the bench samples them in the same half-cycle as the strobe. After a reply commit, the request line drops only on the second edge: one edge for the pending length and one for `req_n`. The bench waits two cycles before it checks that.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic {
        HS_IDLE   = 1'b0,
        HS_ACTIVE = 1'b1
    } hs_state_t;

    localparam int OFS_SHIFT   = 10;
    localparam int OFS_AUX     = 11;
    localparam int AUX_DIR_BIT = 4;
endpackage

// File: rtl/hs_fsm.sv
module hs_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_n,
    input  logic ack_n,
    output logic ev_byte,
    output logic ev_sync,
    output logic ev_end
);
    hs_state_t state_q, state_d;
    logic      ack_q;
    logic      prev_xfer_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (!xfer_n) state_d = HS_ACTIVE;  // START
            HS_ACTIVE: if (xfer_n)  state_d = HS_IDLE;    // FINISH
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            ack_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_n;
        end
    end

    assign prev_xfer_n = (state_q == HS_IDLE);

    always_comb begin
        ev_byte = !xfer_n && ({xfer_n, ack_n} != {prev_xfer_n, ack_q});
        ev_sync = xfer_n && prev_xfer_n && (ack_n != ack_q);
        ev_end  = xfer_n && !prev_xfer_n;
    end
endmodule

// File: rtl/hs_rxbuf.sv
module hs_rxbuf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          full,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (push && !full) mem[count[IW-1:0]] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (clear)          count <= '0;
        else if (push && !full)  count <= count + CW'(1);
    end
endmodule

// File: rtl/hs_txbuf.sv
module hs_txbuf #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic [CW-1:0] commit_len,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          pending,
    output logic          last
);
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] idx_q, len_q;

    assign head    = mem[idx_q[IW-1:0]];
    assign pending = (idx_q < len_q);
    assign last    = pending && ((idx_q + CW'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else if (commit) begin
            idx_q <= '0;
            len_q <= (commit_len > CW'(DEPTH)) ? CW'(DEPTH) : commit_len;
        end else if (pop && pending) begin
            idx_q <= idx_q + CW'(1);
        end
    end
endmodule

// File: rtl/shift_handshake.sv
module shift_handshake
    import hs_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 128,
    parameter int DW       = 8,
    parameter int AW       = 4,
    localparam int RX_IW   = $clog2(RX_DEPTH),
    localparam int RX_CW   = $clog2(RX_DEPTH + 1),
    localparam int TX_IW   = $clog2(TX_DEPTH),
    localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_n,
    input  logic             ack_n,
    output logic             req_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             sr_irq,
    output logic             pkt_done,
    output logic [RX_CW-1:0] pkt_len,
    input  logic [RX_IW-1:0] rx_rd_idx,
    output logic [DW-1:0]    rx_rd_data,
    input  logic             tx_wr_en,
    input  logic [TX_IW-1:0] tx_wr_idx,
    input  logic [DW-1:0]    tx_wr_data,
    input  logic             tx_commit,
    input  logic [TX_CW-1:0] tx_commit_len
);
    logic             ev_byte, ev_sync, ev_end;
    logic [RX_CW-1:0] rx_count;
    logic             rx_full;
    logic [DW-1:0]    tx_head;
    logic             tx_pending, tx_last;
    logic [DW-1:0]    shift_q, aux_q;
    logic             dir_rx, rx_push, tx_pop, stored, irq_set;
    logic             acc_shift, acc_aux;

    hs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_n  (xfer_n),
        .ack_n   (ack_n),
        .ev_byte (ev_byte),
        .ev_sync (ev_sync),
        .ev_end  (ev_end)
    );

    hs_rxbuf #(.DEPTH(RX_DEPTH), .DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (shift_q),
        .clear     (ev_end),
        .count     (rx_count),
        .full      (rx_full),
        .rd_idx    (rx_rd_idx),
        .rd_data   (rx_rd_data)
    );

    hs_txbuf #(.DEPTH(TX_DEPTH), .DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tx_wr_en),
        .wr_idx     (tx_wr_idx),
        .wr_data    (tx_wr_data),
        .commit     (tx_commit),
        .commit_len (tx_commit_len),
        .pop        (tx_pop),
        .head       (tx_head),
        .pending    (tx_pending),
        .last       (tx_last)
    );

    always_comb begin
        acc_shift = (bus_addr == AW'(OFS_SHIFT));
        acc_aux   = (bus_addr == AW'(OFS_AUX));
        dir_rx    = aux_q[AUX_DIR_BIT];
        rx_push   = ev_byte && dir_rx;
        tx_pop    = ev_byte && !dir_rx && tx_pending;
        stored    = rx_push && !rx_full;
        irq_set   = stored || tx_pop || ev_sync || ev_end;
        if (acc_shift)    bus_rdata = shift_q;
        else if (acc_aux) bus_rdata = aux_q;
        else              bus_rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            aux_q    <= '0;
            sr_irq   <= 1'b0;
            req_n    <= 1'b1;
            pkt_done <= 1'b0;
            pkt_len  <= '0;
        end else begin
            if (tx_pop)                   shift_q <= tx_head;
            else if (bus_wr && acc_shift) shift_q <= bus_wdata;

            if (bus_wr && acc_aux) aux_q <= bus_wdata;

            if (irq_set)                  sr_irq <= 1'b1;
            else if (bus_rd && acc_shift) sr_irq <= 1'b0;

            if (tx_pop && tx_last)          req_n <= 1'b1;
            else if (ev_sync)               req_n <= ack_n;
            else if (xfer_n && tx_pending)  req_n <= 1'b0;

            pkt_done <= ev_end && (rx_count != '0);
            pkt_len  <= rx_count;
        end
    end
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int RX_DEPTH = 16,
    parameter int CW       = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_n,
    input logic          ack_n,
    input logic          req_n,
    input logic          sr_irq,
    input logic          pkt_done,
    input logic [CW-1:0] pkt_len,
    input logic          tx_pending
);
    p_pkt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    p_pkt_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0 && pkt_len <= CW'(RX_DEPTH)));

    p_end_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_n) |=> sr_irq);

    p_sync_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_n && $past(xfer_n) && ack_n != $past(ack_n)) |=> (req_n == $past(ack_n)));

    p_sync_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_n && $past(xfer_n) && ack_n != $past(ack_n)) |=> sr_irq);

    p_idle_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_n && $past(xfer_n) && ack_n == $past(ack_n) && tx_pending) |=> !req_n);
endmodule

bind shift_handshake hs_checker #(.RX_DEPTH(RX_DEPTH), .CW(RX_CW)) u_hs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_n     (xfer_n),
    .ack_n      (ack_n),
    .req_n      (req_n),
    .sr_irq     (sr_irq),
    .pkt_done   (pkt_done),
    .pkt_len    (pkt_len),
    .tx_pending (tx_pending)
);

// File: tb/shift_handshake_test.sv
module shift_handshake_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_n = 1'b1, ack_n = 1'b1;
    logic       req_n;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sr_irq, pkt_done;
    logic [4:0] pkt_len;
    logic [3:0] rx_rd_idx = '0;
    logic [7:0] rx_rd_data;
    logic       tx_wr_en = 1'b0;
    logic [6:0] tx_wr_idx = '0;
    logic [7:0] tx_wr_data = '0;
    logic       tx_commit = 1'b0;
    logic [7:0] tx_commit_len = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shift_handshake uut (
        .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .ack_n(ack_n), .req_n(req_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sr_irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .rx_rd_idx(rx_rd_idx), .rx_rd_data(rx_rd_data),
        .tx_wr_en(tx_wr_en), .tx_wr_idx(tx_wr_idx), .tx_wr_data(tx_wr_data),
        .tx_commit(tx_commit), .tx_commit_len(tx_commit_len)
    );

    // {xfer_n, ack_n, exp_req_n, exp_irq, exp_done, exp_len[4:0]}
    localparam logic [9:0] VEC [0:10] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0},  // sync, req follows low
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},  // sync, req follows high
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0},  // nothing changes
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},  // start counts as byte
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0},  // second byte
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0},  // held, no byte
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd2},  // release: packet of 2
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0},  // strobe gone
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},  // sync
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},  // one byte
        {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd1}   // release: packet of 1
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic tx_put(input logic [6:0] i, input logic [7:0] d);
        tx_wr_idx = i; tx_wr_data = d; tx_wr_en = 1'b1;
        tick();
        tx_wr_en = 1'b0;
    endtask

    task automatic tx_go(input logic [7:0] n);
        tx_commit_len = n; tx_commit = 1'b1;
        tick();
        tx_commit = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 req_n", req_n, 1'b1);
        check("R1 sr_irq", sr_irq, 1'b0);
        check("R1 pkt_done", pkt_done, 1'b0);
        bus_read(4'd10, rd);
        check("R1 shift reads 0", rd, 8'h00);

        // R11 aux register and other offsets
        bus_write(4'd11, 8'h10);
        bus_read(4'd11, rd);
        check("R11 aux readback", rd, 8'h10);
        bus_read(4'd3, rd);
        check("R11 other offset", rd, 8'h00);

        // R9 write/read of shift register
        bus_write(4'd10, 8'hA5);
        bus_read(4'd10, rd);
        check("R9 shift readback", rd, 8'hA5);

        // Table: R2, R6, R7 sequences
        for (int i = 0; i < 11; i++) begin
            xfer_n = VEC[i][9];
            ack_n  = VEC[i][8];
            tick();
            check($sformatf("R6/R2/R7 vec%0d req_n", i), req_n, VEC[i][7]);
            check($sformatf("R6/R2/R7 vec%0d sr_irq", i), sr_irq, VEC[i][6]);
            check($sformatf("R7 vec%0d pkt_done", i), pkt_done, VEC[i][5]);
            if (VEC[i][5]) check($sformatf("R7 vec%0d pkt_len", i), pkt_len, VEC[i][4:0]);
            bus_read(4'd10, rd);
            check($sformatf("R9 vec%0d irq cleared", i), sr_irq, 1'b0);
        end
        rx_rd_idx = 4'd0; #1;
        check("R2 slot0 content", rx_rd_data, 8'hA5);

        // R9 set beats clear in same cycle (sync event with read)
        bus_addr = 4'd10; bus_rd = 1'b1; ack_n = 1'b0;
        tick();
        bus_rd = 1'b0;
        check("R9 set wins over clear", sr_irq, 1'b1);
        check("R6 req follows ack", req_n, 1'b0);
        ack_n = 1'b1;
        tick();
        check("R6 req follows ack high", req_n, 1'b1);
        bus_read(4'd10, rd);

        // R2/R3 fill and overflow
        bus_write(4'd10, 8'h40);
        xfer_n = 1'b0;
        tick();
        for (int i = 1; i < 18; i++) begin
            bus_write(4'd10, 8'(8'h40 + i));
            if (i == 16) bus_read(4'd10, rd);
            ack_n = ~ack_n;
            tick();
            if (i >= 16) check($sformatf("R3 dropped byte %0d no irq", i), sr_irq, 1'b0);
        end
        for (int s = 0; s < 16; s++) begin
            rx_rd_idx = 4'(s); #1;
            check($sformatf("R2/R3 slot%0d", s), rx_rd_data, 8'(8'h40 + s));
        end
        xfer_n = 1'b1;
        tick();
        check("R7/R3 full packet done", pkt_done, 1'b1);
        check("R7/R3 full packet len", pkt_len, 5'd16);
        check("R7 irq on release", sr_irq, 1'b1);
        tick();
        check("R7 strobe one cycle", pkt_done, 1'b0);
        ack_n = 1'b1;
        tick();
        bus_read(4'd10, rd);

        // R4/R5/R8/R10 device-to-host
        bus_write(4'd11, 8'h00);
        tx_put(7'd0, 8'h11);
        tx_put(7'd1, 8'h22);
        tx_put(7'd2, 8'h33);
        tx_go(8'd3);
        tick();
        check("R8/R10 req asserted when pending", req_n, 1'b0);
        bus_read(4'd10, rd);
        xfer_n = 1'b0;
        tick();
        check("R4 first load irq", sr_irq, 1'b1);
        check("R4 req held low mid reply", req_n, 1'b0);
        bus_read(4'd10, rd);
        check("R4 first byte", rd, 8'h11);
        ack_n = 1'b0;
        tick();
        bus_read(4'd10, rd);
        check("R4 second byte", rd, 8'h22);
        ack_n = 1'b1;
        tick();
        check("R5 req released on last", req_n, 1'b1);
        bus_read(4'd10, rd);
        check("R4 third byte", rd, 8'h33);
        ack_n = 1'b0;
        tick();
        check("R4 no pending no irq", sr_irq, 1'b0);
        bus_read(4'd10, rd);
        check("R4 no pending keeps shift", rd, 8'h33);
        xfer_n = 1'b1;
        tick();
        check("R7 irq on empty release", sr_irq, 1'b1);
        check("R7 no strobe when empty", pkt_done, 1'b0);
        check("R8 no pending keeps req high", req_n, 1'b1);
        ack_n = 1'b1;
        tick();
        bus_read(4'd10, rd);

        // R10 recommit restarts from slot 0
        tx_put(7'd0, 8'h77);
        tx_put(7'd1, 8'h88);
        tx_go(8'd2);
        tick();
        xfer_n = 1'b0;
        tick();
        bus_read(4'd10, rd);
        check("R10 first of reply", rd, 8'h77);
        xfer_n = 1'b1;
        tick();
        check("R8 req low with byte left", req_n, 1'b0);
        tx_go(8'd2);
        xfer_n = 1'b0;
        tick();
        bus_read(4'd10, rd);
        check("R10 index reset on commit", rd, 8'h77);
        xfer_n = 1'b1;
        tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule